// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing half of a byte-wide serial EEPROM that sits on a two-wire I2C bus. It oversamples the clock and data lines on the system clock, finds bus START and STOP events, and recognises its own device address. That address has a fixed `1010` type prefix, followed by three select bits taken from strap inputs. Every byte the block accepts is acknowledged on the ninth bus clock by pulling the data line low.

A write transaction carries a 16-bit memory pointer as two bytes, high byte first, and then any number of data bytes. The data bytes collect in a 64-byte page buffer and are committed to a small on-chip synchronous RAM when the master issues STOP. A busy interval of a configurable number of clock cycles follows and models the nonvolatile programming time. During that interval the block ignores its address entirely. A read transaction streams bytes from the pointer, advancing it after every master acknowledge, until the master declines a byte.

The data line is open drain. The block only ever pulls it low through `sdaDriveLow`, and the surrounding pad logic turns that into a pull-down.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset `sdaDriveLow` and `busy` are both 0.
- R2: SDA falling while SCL is high is a START and aborts any partly received byte; the block then expects a fresh address byte.
- R3: The address byte is {4'b1010, devSel[2:0], rw} sent MSB first; only on a match does the block pull SDA low during the ninth SCL clock, and after a mismatch it drives nothing until the next START.
- R4: With rw = 0 the next two bytes load the pointer (high byte first) and each data byte after them is acknowledged.
- R5: Write data goes to a 64-byte page buffer; the pointer's low 6 bits advance per byte and wrap inside the page, leaving bits 15:6 unchanged, so later bytes overwrite earlier ones at the same offset.
- R6: STOP after at least one data byte commits the page and raises `busy` for exactly PROG_CYCLES clock cycles; STOP with no data byte leaves `busy` at 0.
- R7: While `busy` is 1 the block does not acknowledge its own address.
- R8: With rw = 1 the block sends the byte at the pointer MSB first (RAM index = pointer[MEM_AW-1:0]); a master ACK (SDA low on the ninth clock) advances the 16-bit pointer and sends the next byte, wrapping from 0xFFFF to 0x0000; a NACK releases SDA until the next START.
- R9: `sdaDriveLow` is raised only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| devSel | input | 3 | Strapped low bits of the device address |
| sdaDriveLow | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Programming interval in progress |

## Verification
The embedded assertions watch several things on every cycle. They check that the data line is pulled only after SCL has gone low, and that a START always lands the controller in the address phase with the line released. They also check that the bit counter stays in range, that a declined read byte releases the bus, that at most one datapath strobe fires per cycle, that page writes never move the pointer outside its page, and that busy only ever starts from a commit. Other behaviour spans whole transactions and only the bench scenarios can show it: the stored bytes coming back, the in-page wraparound and the 16-bit pointer rollover, the exact busy length, and the refusal to answer during programming. The bench checks these against a byte model of the RAM under random page writes and directed corner cases.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

  localparam int PTR_W = 16;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic bufWrite;
    logic ptrInc;
    logic commit;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_RDAT
  } ctrlState_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclLevel = sclPipe[SYNC_STAGES-1];
  assign sdaLevel = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclLevel && !sclPrev;
  assign sclFall  = !sclLevel && sclPrev;
  assign startDet = sclLevel && sclPrev && sdaPrev && !sdaLevel;
  assign stopDet  = sclLevel && sclPrev && !sdaPrev && sdaLevel;

endmodule

// File: rtl/eeprom_i2c_ctrl.sv
module eeprom_i2c_ctrl
  import eeprom_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLevel,
  input  logic       sdaLevel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [2:0] devSel,
  input  logic [7:0] rxByte,
  input  logic [7:0] rdData,
  input  logic       busy,
  output dpStrobe_t  st,
  output logic       sdaDriveLow
);

  ctrlState_t state;
  ctrlState_t ackNext;
  ctrlState_t ackTarget;
  logic [3:0] bitCnt;
  logic       inAck;
  logic       drive;
  logic       rxStage;
  logic       byteDone;
  logic       devMatch;
  logic [2:0] txIdx;

  assign rxStage  = (state == S_DEV) || (state == S_AHI) ||
                    (state == S_ALO) || (state == S_WDAT);
  assign byteDone = rxStage && sclFall && !inAck && (bitCnt == 4'd8);
  assign devMatch = (rxByte[7:1] == {DEV_TYPE, devSel}) && !busy;
  assign txIdx    = 3'd7 - bitCnt[2:0];

  always_comb begin
    case (state)
      S_DEV:   ackTarget = rxByte[0] ? S_RDAT : S_AHI;
      S_AHI:   ackTarget = S_ALO;
      default: ackTarget = S_WDAT;
    endcase
  end

  always_comb begin
    st          = '0;
    st.shiftIn  = rxStage && sclRise && !inAck && (bitCnt < 4'd8);
    st.loadHi   = byteDone && (state == S_AHI);
    st.loadLo   = byteDone && (state == S_ALO);
    st.bufWrite = byteDone && (state == S_WDAT);
    st.ptrInc   = (state == S_RDAT) && sclRise && (bitCnt == 4'd8) && !sdaLevel;
    st.commit   = stopDet && (state == S_WDAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      ackNext <= S_IDLE;
      bitCnt  <= '0;
      inAck   <= 1'b0;
      drive   <= 1'b0;
    end else if (startDet) begin
      state  <= S_DEV;
      bitCnt <= '0;
      inAck  <= 1'b0;
      drive  <= 1'b0;
    end else if (stopDet) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      inAck  <= 1'b0;
      drive  <= 1'b0;
    end else if (rxStage) begin
      if (sclRise && !inAck && (bitCnt < 4'd8)) begin
        bitCnt <= bitCnt + 4'd1;
      end else if (sclFall && inAck) begin
        inAck  <= 1'b0;
        bitCnt <= '0;
        state  <= ackNext;
        drive  <= (ackNext == S_RDAT) ? ~rdData[7] : 1'b0;
      end else if (byteDone) begin
        if ((state == S_DEV) && !devMatch) begin
          state  <= S_IDLE;
          bitCnt <= '0;
        end else begin
          inAck   <= 1'b1;
          drive   <= 1'b1;
          ackNext <= ackTarget;
        end
      end
    end else if (state == S_RDAT) begin
      if (sclRise) begin
        if (bitCnt == 4'd8) begin
          if (sdaLevel) begin
            state  <= S_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= 4'd9;
          end
        end else begin
          bitCnt <= bitCnt + 4'd1;
        end
      end else if (sclFall) begin
        if (bitCnt == 4'd9) begin
          bitCnt <= '0;
          drive  <= ~rdData[7];
        end else if (bitCnt == 4'd8) begin
          drive <= 1'b0;
        end else begin
          drive <= ~rdData[txIdx];
        end
      end
    end
  end

  assign sdaDriveLow = drive;

  // R9: the line is only pulled after SCL was seen low
  a_r9_pull_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !$past(sclLevel));

  // R2: START lands in the address phase with the line released
  a_r2_start_resets: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == S_DEV) && (bitCnt == 4'd0) && !sdaDriveLow);

  // R3: bit counter never leaves its range
  a_r3_bitcnt_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd9);

  // R7: no address acknowledge while programming
  a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DEV) && busy && !inAck |=> !sdaDriveLow);

  // R8: a declined read byte releases the bus
  a_r8_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RDAT) && sclRise && (bitCnt == 4'd8) && sdaLevel
      |=> (state == S_IDLE) && !sdaDriveLow);

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_i2c_pkg::*;
#(
  parameter int MEM_AW      = 10,
  parameter int PAGE_AW     = 6,
  parameter int PROG_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  st,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic [7:0] rdData,
  output logic       busy
);

  localparam int PAGE  = 1 << PAGE_AW;
  localparam int DEPTH = 1 << MEM_AW;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [7:0]         shiftReg;
  logic [PTR_W-1:0]   ptr;
  logic [7:0]         pageBuf [PAGE];
  logic [PAGE-1:0]    valid;
  logic [7:0]         mem [DEPTH];
  logic [CNT_W-1:0]   busyCnt;
  logic [PAGE_AW:0]   commitIdx;
  logic               busyR;
  logic               ramWe;
  logic [MEM_AW-1:0]  ramWrAddr;
  logic [PAGE_AW-1:0] bufIdx;
  logic               busyDone;

  assign bufIdx   = ptr[PAGE_AW-1:0];
  assign busyDone = busyR && (busyCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (st.shiftIn) begin
      shiftReg <= {shiftReg[6:0], sdaBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (st.loadHi) begin
      ptr[PTR_W-1:8] <= shiftReg;
    end else if (st.loadLo) begin
      ptr[7:0] <= shiftReg;
    end else if (st.bufWrite) begin
      ptr[PAGE_AW-1:0] <= bufIdx + 1'b1;
    end else if (st.ptrInc) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.bufWrite) begin
      pageBuf[bufIdx] <= shiftReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0;
    end else if (st.loadLo || busyDone) begin
      valid <= '0;
    end else if (st.bufWrite) begin
      valid[bufIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR     <= 1'b0;
      busyCnt   <= '0;
      commitIdx <= '0;
    end else if (st.commit && (|valid)) begin
      busyR     <= 1'b1;
      busyCnt   <= CNT_W'(PROG_CYCLES - 1);
      commitIdx <= '0;
    end else if (busyR) begin
      if (busyDone) begin
        busyR <= 1'b0;
      end else begin
        busyCnt <= busyCnt - 1'b1;
      end
      if (!commitIdx[PAGE_AW]) begin
        commitIdx <= commitIdx + 1'b1;
      end
    end
  end

  assign ramWe     = busyR && !commitIdx[PAGE_AW] && valid[commitIdx[PAGE_AW-1:0]];
  assign ramWrAddr = {ptr[MEM_AW-1:PAGE_AW], commitIdx[PAGE_AW-1:0]};

  always_ff @(posedge clk) begin
    if (ramWe) begin
      mem[ramWrAddr] <= pageBuf[commitIdx[PAGE_AW-1:0]];
    end
    rdData <= mem[ptr[MEM_AW-1:0]];
  end

  assign rxByte = shiftReg;
  assign busy   = busyR;

  // R6: programming only starts from a commit request
  a_r6_busy_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(st.commit));

  // R4: control never fires two datapath actions together
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.loadHi, st.loadLo, st.bufWrite, st.ptrInc, st.commit}));

  // R5: page writes never leave the current page
  a_r5_page_wrap: assert property (@(posedge clk) disable iff (!rstN)
    st.bufWrite |=> ptr[PTR_W-1:PAGE_AW] == $past(ptr[PTR_W-1:PAGE_AW]));

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_i2c_pkg::*;
#(
  parameter int MEM_AW      = 10,
  parameter int PAGE_AW     = 6,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] devSel,
  output logic       sdaDriveLow,
  output logic       busy
);

  logic       sclLevel;
  logic       sdaLevel;
  logic       sclRise;
  logic       sclFall;
  logic       startDet;
  logic       stopDet;
  logic [7:0] rxByte;
  logic [7:0] rdData;
  dpStrobe_t  st;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclLevel (sclLevel),
    .sdaLevel (sdaLevel),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  eeprom_i2c_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclLevel    (sclLevel),
    .sdaLevel    (sdaLevel),
    .sclRise     (sclRise),
    .sclFall     (sclFall),
    .startDet    (startDet),
    .stopDet     (stopDet),
    .devSel      (devSel),
    .rxByte      (rxByte),
    .rdData      (rdData),
    .busy        (busy),
    .st          (st),
    .sdaDriveLow (sdaDriveLow)
  );

  eeprom_datapath #(
    .MEM_AW      (MEM_AW),
    .PAGE_AW     (PAGE_AW),
    .PROG_CYCLES (PROG_CYCLES)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .sdaBit (sdaLevel),
    .rxByte (rxByte),
    .rdData (rdData),
    .busy   (busy)
  );

endmodule

// File: tb/sim_eeprom_i2c_slave.sv
module sim_eeprom_i2c_slave;

  localparam int PROG  = 600;
  localparam int HALF  = 12;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] devSel = 3'b101;
  logic sdaDriveLow;
  logic busy;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaDriveLow;

  always #2 clk = ~clk;

  eeprom_i2c_slave #(.PROG_CYCLES(PROG)) u0 (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclM),
    .sdaIn       (sdaLine),
    .devSel      (devSel),
    .sdaDriveLow (sdaDriveLow),
    .busy        (busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [1024];

  int busyRun = 0;
  int lastWidth = 0;
  int pullViolations = 0;
  logic prevDrive = 1'b0;

  always @(negedge clk) begin
    if (busy) busyRun++;
    else if (busyRun != 0) begin
      lastWidth = busyRun;
      busyRun = 0;
    end
    if (rstN && sdaDriveLow && !prevDrive && sclM) pullViolations++;
    prevDrive = sdaDriveLow;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] devByte(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction

  function automatic logic [15:0] pageAddr(input logic [15:0] base, input int i);
    logic [5:0] off;
    off = base[5:0] + 6'(i);
    return {base[15:6], off};
  endfunction

  task automatic busStart();
    sdaM = 1'b1; tick(HALF/2);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b0; tick(HALF/2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(HALF/2);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b1; tick(HALF);
  endtask

  task automatic bitOut(input logic b);
    sdaM = b; tick(HALF/2);
    sclM = 1'b1; tick(HALF);
    sclM = 1'b0; tick(HALF/2);
  endtask

  task automatic bitIn(output logic b);
    sdaM = 1'b1; tick(HALF/2);
    sclM = 1'b1; tick(HALF/2);
    b = sdaLine; tick(HALF/2);
    sclM = 1'b0; tick(HALF/2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic v;
    for (int k = 7; k >= 0; k--) bitOut(b[k]);
    bitIn(v);
    acked = !v;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    logic v;
    for (int k = 7; k >= 0; k--) begin
      bitIn(v);
      b[k] = v;
    end
    bitOut(!ackIt);
  endtask

  task automatic setPointer(input logic [15:0] addr, input string tag);
    logic a;
    busStart();
    sendByte(devByte(devSel, 1'b0), a);
    check({tag, " R3 own address acked"}, a, 1);
    sendByte(addr[15:8], a);
    check({tag, " R4 high pointer byte acked"}, a, 1);
    sendByte(addr[7:0], a);
    check({tag, " R4 low pointer byte acked"}, a, 1);
  endtask

  task automatic writeSeq(input logic [15:0] addr, input int n, input string tag);
    logic a;
    logic [7:0] d;
    logic [15:0] p;
    setPointer(addr, tag);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      sendByte(d, a);
      check({tag, " R4 data byte acked"}, a, 1);
      p = pageAddr(addr, i);
      model[p[9:0]] = d;
    end
    busStop();
  endtask

  task automatic waitIdle(input string tag);
    int t;
    t = 0;
    while (busy && t < 20000) begin
      tick(1);
      t++;
    end
    tick(2);
    check({tag, " R6 busy width"}, lastWidth, PROG);
    lastWidth = 0;
  endtask

  task automatic readSeq(input logic [15:0] addr, input int n, input string tag);
    logic a;
    logic [7:0] b;
    logic [15:0] p;
    setPointer(addr, tag);
    busStart();
    sendByte(devByte(devSel, 1'b1), a);
    check({tag, " R3 read address acked"}, a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      p = addr + 16'(i);
      check({tag, " R8 read data"}, b, model[p[9:0]]);
    end
    tick(2 * HALF);
    check({tag, " R8 line released after NACK"}, sdaDriveLow, 0);
    busStop();
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d cycles", LIMIT, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [15:0] ra;
    int off;
    int maxn;
    int n;
    void'($urandom(32'd1234));

    tick(5);
    check("R1 drive at reset", sdaDriveLow, 0);
    check("R1 busy at reset", busy, 0);
    rstN = 1'b1;
    tick(5);

    // R3: wrong select bits and wrong type prefix are ignored
    busStart();
    sendByte(devByte(3'b010, 1'b0), a);
    check("R3 wrong select not acked", a, 0);
    sendByte(8'h00, a);
    check("R3 following byte ignored", a, 0);
    busStop();
    busStart();
    sendByte({4'b1011, devSel, 1'b0}, a);
    check("R3 wrong prefix not acked", a, 0);
    busStop();

    // R6: STOP without data starts nothing
    setPointer(16'h0200, "nodata");
    busStop();
    tick(4);
    check("R6 no busy without data", busy, 0);

    // R4/R6/R7: short write, probe during programming
    writeSeq(16'h0123, 3, "short");
    check("R6 busy after STOP", busy, 1);
    busStart();
    sendByte(devByte(devSel, 1'b0), a);
    check("R7 no ack while busy", a, 0);
    busStop();
    waitIdle("short");
    readSeq(16'h0123, 3, "short");

    // R5: 68 bytes from offset 60 wrap inside the page
    writeSeq(16'h013C, 68, "R5 wrap");
    waitIdle("R5 wrap");
    readSeq(16'h0100, 64, "R5 wrap");

    // R8: read crossing a page boundary
    writeSeq(16'h0140, 2, "cross");
    waitIdle("cross");
    readSeq(16'h013E, 4, "cross");

    // R2: START in the middle of an address byte aborts it
    busStart();
    for (int k = 7; k >= 4; k--) bitOut(devByte(devSel, 1'b0) >> k);
    writeSeq(16'h0050, 1, "R2 abort");
    waitIdle("R2 abort");
    readSeq(16'h0050, 1, "R2 abort");

    // R8: 16-bit pointer rollover
    writeSeq(16'hFFFF, 1, "roll");
    waitIdle("roll");
    writeSeq(16'h0000, 1, "roll");
    waitIdle("roll");
    readSeq(16'hFFFF, 2, "R8 rollover");

    // random page writes read back
    for (int it = 0; it < 8; it++) begin
      ra = 16'($urandom);
      off = 64 - int'(ra[5:0]);
      maxn = (off < 12) ? off : 12;
      n = 1 + int'($urandom % maxn);
      writeSeq(ra, n, "random");
      waitIdle("random");
      readSeq(ra, n, "random");
    end

    check("R9 pulls only while SCL low", pullViolations, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule